// File: doc/BRIEF.md
# Lock Elision Outcome Predictor

This block advises a locking primitive whether a critical section should first be tried as a hardware transaction or whether the lock should be taken at once. The requester presents an identity key on the lookup port. One cycle later the block answers either "elide" (start a transaction) or "acquire" (take the lock directly, with no transaction). Once the attempt has finished, the requester reports what happened on the update port: the transaction committed, it aborted on a data conflict, or it gave up and fell back to the real lock. A fallback counts as a failed elision.

The identity comes from one of three sources, chosen by a mode input: the lock variable's address (the default), the instruction address of the acquire, or an identifier supplied by software. Address keys lose their cache-line offset bits. Every key is then XOR-folded into a table index, and the bits directly above the index field form a partial tag. The table is direct-mapped. Each entry holds a valid bit, a partial tag and a 2-bit saturating confidence counter.

Top module: `elide_pred_top`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and clears the response valid output. The first lookup of any key after reset answers elide.
- R2: A lookup presented at a clock edge raises the response valid output for exactly the following cycle, carrying the decision (1 = elide, 0 = acquire).
- R3: The mode input picks the key source for both ports: 0 selects the lock address, 1 the instruction address, 2 the software identifier, and 3 behaves like 0.
- R4: For address keys, the low 6 bits are dropped. The remaining bits are XOR-folded in 6-bit chunks, starting at bit 0, to form the 6-bit index. The tag is the 6 bits just above the index field, so keys that differ only in offset bits or in bit pairs that cancel in the fold share an entry.
- R5: Software identifiers are folded from bit 0, with no offset bits dropped.
- R6: A lookup whose entry is invalid or holds a different tag answers elide. It allocates the entry with the key's tag and a counter value of 2 (weakly elide).
- R7: Update outcome encoding is 0 = commit, 1 = conflict abort, 2 = fallback to lock, 3 = no effect. Commit raises the counter, saturating at 3. Abort and fallback lower it, saturating at 0.
- R8: A lookup that hits answers elide when the counter is 2 or 3 and acquire when it is 0 or 1.
- R9: An update whose key misses (invalid entry or tag mismatch) leaves the table unchanged.
- R10: When a lookup and a hitting update address the same index in one cycle, the lookup answers from the value before the update, and the update takes precedence over any allocation by that lookup.
- R11: Allocation overwrites an older entry that holds a different tag at the same index, discarding its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_sel | input | 2 | Key source mode for lookup and update |
| lk_valid | input | 1 | Lookup request |
| lk_lock_addr | input | 32 | Lookup lock address |
| lk_pc | input | 32 | Lookup acquire instruction address |
| lk_swid | input | 32 | Lookup software identifier |
| up_valid | input | 1 | Update request |
| up_lock_addr | input | 32 | Update lock address |
| up_pc | input | 32 | Update acquire instruction address |
| up_swid | input | 32 | Update software identifier |
| up_outcome | input | 2 | Attempt outcome for the update |
| rsp_valid | output | 1 | Lookup answer valid, one cycle after request |
| rsp_elide | output | 1 | 1 = attempt elision, 0 = acquire the lock |

## Verification
The hardest situation to reach from the ports is a lookup and a hitting update landing on the same index in the same cycle. This is worst when the lookup key carries a different tag, so that an allocation competes with the counter write. The stimulus first drives one key's counter to a known low value through single updates. It then issues, in one cycle, a lookup of an aliasing key with a foreign tag together with a commit for the resident key. A follow-up lookup of the resident key shows both that it survived and that its counter moved. Folding aliases are reached by building addresses whose upper chunks cancel under XOR, so that each one is proven to land on the trained entry.

// File: rtl/elide_pkg.sv
package elide_pkg;

  typedef enum logic [1:0] {
    KEY_LOCK = 2'd0,
    KEY_PC   = 2'd1,
    KEY_SWID = 2'd2,
    KEY_ALT  = 2'd3
  } key_src_e;

  typedef enum logic [1:0] {
    OUT_COMMIT   = 2'd0,
    OUT_CONFLICT = 2'd1,
    OUT_FALLBACK = 2'd2,
    OUT_NONE     = 2'd3
  } outcome_e;

  localparam int unsigned CNT_W    = 2;
  localparam int unsigned CNT_INIT = 2;

endpackage

// File: rtl/elide_key_fold.sv
module elide_key_fold
  import elide_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned LINE_OFS = 6
) (
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] swid,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  localparam int unsigned NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NCHUNK * IDX_W;

  logic [ADDR_W-1:0] raw_key;
  logic [ADDR_W-1:0] shifted;
  logic [PAD_W-1:0]  padded;
  logic [IDX_W-1:0]  part [NCHUNK+1];

  always_comb begin
    unique case (key_src_e'(sel))
      KEY_PC:   raw_key = pc;
      KEY_SWID: raw_key = swid;
      default:  raw_key = lock_addr;
    endcase
  end

  // Identifiers carry no cache-line offset; addresses do.
  assign shifted = (key_src_e'(sel) == KEY_SWID) ? raw_key : (raw_key >> LINE_OFS);
  assign padded  = PAD_W'(shifted);

  assign part[0] = '0;
  for (genvar c = 0; c < NCHUNK; c++) begin : g_fold
    assign part[c+1] = part[c] ^ padded[c*IDX_W +: IDX_W];
  end

  assign idx = part[NCHUNK];
  assign tag = shifted[IDX_W +: TAG_W];

endmodule

// File: rtl/elide_ctr_step.sv
module elide_ctr_step
  import elide_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] cnt,
  input  logic [1:0]   outcome,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_comb begin
    unique case (outcome_e'(outcome))
      OUT_COMMIT:               nxt = (cnt == TOP)  ? cnt : cnt + 1'b1;
      OUT_CONFLICT, OUT_FALLBACK: nxt = (cnt == '0) ? cnt : cnt - 1'b1;
      default:                  nxt = cnt;
    endcase
  end

endmodule

// File: rtl/elide_table.sv
module elide_table
  import elide_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  // lookup read port
  input  logic [IDX_W-1:0] l_idx,
  output logic             l_vld,
  output logic [TAG_W-1:0] l_tag,
  output logic [W-1:0]     l_cnt,
  // update read port
  input  logic [IDX_W-1:0] u_idx,
  output logic             u_vld,
  output logic [TAG_W-1:0] u_tag,
  output logic [W-1:0]     u_cnt,
  // counter write from update
  input  logic             u_we,
  input  logic [W-1:0]     u_wcnt,
  // allocation from lookup
  input  logic             al_req,
  input  logic [TAG_W-1:0] al_tag
);

  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [W-1:0] INIT = W'(CNT_INIT);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [W-1:0]     cnt_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic             al_we;

  assign l_vld = valid_q[l_idx];
  assign l_tag = tag_mem[l_idx];
  assign l_cnt = cnt_mem[l_idx];
  assign u_vld = valid_q[u_idx];
  assign u_tag = tag_mem[u_idx];
  assign u_cnt = cnt_mem[u_idx];

  // Counter update outranks an allocation aimed at the same slot.
  assign al_we = al_req && !(u_we && (u_idx == l_idx));

  always_ff @(posedge clk) begin
    if (u_we) cnt_mem[u_idx] <= u_wcnt;
    if (al_we) begin
      tag_mem[l_idx] <= al_tag;
      cnt_mem[l_idx] <= INIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (al_we) valid_q[l_idx] <= 1'b1;
  end

  p_valid_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0));

  p_alloc_init_r6: assert property (@(posedge clk) disable iff (rst)
    (al_req && !(u_we && (u_idx == l_idx))) |=>
      (valid_q[$past(l_idx)] && (cnt_mem[$past(l_idx)] == INIT) &&
       (tag_mem[$past(l_idx)] == $past(al_tag))));

  p_upd_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (al_req && u_we && (u_idx == l_idx)) |=>
      ((cnt_mem[$past(u_idx)] == $past(u_wcnt)) &&
       (tag_mem[$past(u_idx)] == $past(u_tag))));

endmodule

// File: rtl/elide_pred_top.sv
module elide_pred_top
  import elide_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned LINE_OFS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        key_sel,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_lock_addr,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [ADDR_W-1:0] lk_swid,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_lock_addr,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_swid,
  input  logic [1:0]        up_outcome,
  output logic              rsp_valid,
  output logic              rsp_elide
);

  localparam int unsigned W = CNT_W;

  logic [IDX_W-1:0] l_idx, u_idx;
  logic [TAG_W-1:0] l_key_tag, u_key_tag;
  logic             l_vld, u_vld;
  logic [TAG_W-1:0] l_tag, u_tag;
  logic [W-1:0]     l_cnt, u_cnt, u_nxt;
  logic             hit_l, hit_u, u_we, al_req, elide_d;

  elide_key_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_OFS(LINE_OFS)) u_fold_lk (
    .sel(key_sel), .lock_addr(lk_lock_addr), .pc(lk_pc), .swid(lk_swid),
    .idx(l_idx), .tag(l_key_tag)
  );

  elide_key_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_OFS(LINE_OFS)) u_fold_up (
    .sel(key_sel), .lock_addr(up_lock_addr), .pc(up_pc), .swid(up_swid),
    .idx(u_idx), .tag(u_key_tag)
  );

  elide_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .W(W)) u_table (
    .clk(clk), .rst(rst),
    .l_idx(l_idx), .l_vld(l_vld), .l_tag(l_tag), .l_cnt(l_cnt),
    .u_idx(u_idx), .u_vld(u_vld), .u_tag(u_tag), .u_cnt(u_cnt),
    .u_we(u_we), .u_wcnt(u_nxt),
    .al_req(al_req), .al_tag(l_key_tag)
  );

  elide_ctr_step #(.W(W)) u_step (
    .cnt(u_cnt), .outcome(up_outcome), .nxt(u_nxt)
  );

  assign hit_l   = l_vld && (l_tag == l_key_tag);
  assign hit_u   = u_vld && (u_tag == u_key_tag);
  assign u_we    = up_valid && hit_u;
  assign al_req  = lk_valid && !hit_l;
  assign elide_d = !hit_l || l_cnt[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_elide <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_elide <= lk_valid ? elide_d : rsp_elide;
    end
  end

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_resp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  p_miss_elide_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !hit_l) |=> rsp_elide);

  p_weak_acquire_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hit_l && (l_cnt < W'(2))) |=> !rsp_elide);

  p_step_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    u_we |-> ((u_nxt == u_cnt) || (u_nxt == u_cnt + 1'b1) || (u_nxt == u_cnt - 1'b1)));

  p_miss_untouched_r9: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !hit_u && !lk_valid) |=> (u_table.cnt_mem[$past(u_idx)] == $past(u_cnt)));

endmodule

// File: tb/test_elide_pred_top.sv
module test_elide_pred_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  key_sel = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_lock_addr = '0, lk_pc = '0, lk_swid = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_lock_addr = '0, up_pc = '0, up_swid = '0;
  logic [1:0]  up_outcome = '0;
  logic        rsp_valid, rsp_elide;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  elide_pred_top i_elide_pred_top (
    .clk(clk), .rst(rst), .key_sel(key_sel),
    .lk_valid(lk_valid), .lk_lock_addr(lk_lock_addr), .lk_pc(lk_pc), .lk_swid(lk_swid),
    .up_valid(up_valid), .up_lock_addr(up_lock_addr), .up_pc(up_pc), .up_swid(up_swid),
    .up_outcome(up_outcome), .rsp_valid(rsp_valid), .rsp_elide(rsp_elide)
  );

  localparam logic [31:0] KA = 32'h0000_2040;  // index 3, tag 2
  localparam logic [31:0] KB = 32'h0100_2000;  // folds onto KA
  localparam logic [31:0] KC = 32'h0000_3000;  // index 3, tag 3
  localparam logic [31:0] KE = 32'h0000_0100;  // index 4, tag 0
  localparam logic [31:0] KF = 32'h0000_1140;  // index 4, tag 1

  // {lookup, update, outcome[1:0], expected elide}
  localparam int NV = 19;
  localparam logic [4:0] VEC [NV] = '{
    5'b10001, 5'b01010, 5'b10000, 5'b01000, 5'b10001,
    5'b01000, 5'b01000, 5'b01010, 5'b10001, 5'b01100,
    5'b10000, 5'b01010, 5'b01010, 5'b01000, 5'b10000,
    5'b01000, 5'b10001, 5'b01110, 5'b10001
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] sel, input logic lk, input logic [31:0] la,
                     input logic [31:0] lp, input logic [31:0] li,
                     input logic up, input logic [31:0] ua, input logic [1:0] oc);
    @(negedge clk);
    key_sel = sel; lk_valid = lk; lk_lock_addr = la; lk_pc = lp; lk_swid = li;
    up_valid = up; up_lock_addr = ua; up_pc = ua; up_swid = ua; up_outcome = oc;
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    up_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] k, input logic exp, input string req);
    cyc(2'd0, 1'b1, k, 32'h0, 32'h0, 1'b0, 32'h0, 2'd0);
    chk(rsp_valid && rsp_elide == exp, req, {rsp_valid, rsp_elide}, {1'b1, exp});
  endtask

  task automatic upd(input logic [31:0] k, input logic [1:0] oc);
    cyc(2'd0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, k, oc);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 valid low in reset", rsp_valid, 0);
    @(negedge clk);
    rst = 1'b0;

    // Vector walk on one key: R6 first miss, R7 steps/saturation, R8 thresholds
    for (int i = 0; i < NV; i++) begin
      cyc(2'd0, VEC[i][4], KA, 32'h0, 32'h0, VEC[i][3], KA, VEC[i][2:1]);
      if (VEC[i][4])
        chk(rsp_valid && rsp_elide == VEC[i][0], "R7/R8 vector", {rsp_valid, rsp_elide}, {1'b1, VEC[i][0]});
    end

    // R2: idle cycle gives no response
    cyc(2'd0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, 2'd0);
    chk(rsp_valid == 1'b0, "R2 no response when idle", rsp_valid, 0);

    // R1: reset forgets a trained entry
    upd(KA, 2'd1); upd(KA, 2'd1);
    look(KA, 1'b0, "R8 trained to acquire");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(KA, 1'b1, "R1 entry invalid after reset");

    // Drive KA to 0 for the aliasing checks
    upd(KA, 2'd2); upd(KA, 2'd1);
    look(KA, 1'b0, "R7 fallback lowers counter");

    // R3: source selection
    cyc(2'd1, 1'b1, 32'h0, KA, 32'h0, 1'b0, 32'h0, 2'd0);
    chk(rsp_elide == 1'b0, "R3 mode 1 uses instruction address", rsp_elide, 0);
    cyc(2'd3, 1'b1, KA, 32'h0, 32'h0, 1'b0, 32'h0, 2'd0);
    chk(rsp_elide == 1'b0, "R3 mode 3 uses lock address", rsp_elide, 0);
    // R4: offset dropped and XOR fold
    look(KA | 32'h3F, 1'b0, "R4 line offset ignored");
    look(KB, 1'b0, "R4 upper chunk folded");
    // R5: identifier not shifted
    cyc(2'd2, 1'b1, 32'h0, 32'h0, 32'h81, 1'b0, 32'h0, 2'd0);
    chk(rsp_elide == 1'b0, "R5 identifier folded from bit 0", rsp_elide, 0);

    // R9: updates with a foreign tag are ignored
    upd(KC, 2'd0); upd(KC, 2'd0);
    look(KA, 1'b0, "R9 foreign-tag commit ignored");
    look(KE, 1'b1, "R6 miss allocates");
    upd(KF, 2'd1); upd(KF, 2'd1);
    look(KE, 1'b1, "R9 foreign-tag abort ignored");

    // R10: same-cycle lookup sees the pre-update value
    cyc(2'd0, 1'b1, KA, 32'h0, 32'h0, 1'b1, KA, 2'd0);
    chk(rsp_elide == 1'b0, "R10 pre-update value at 0", rsp_elide, 0);
    look(KA, 1'b0, "R10 update applied to 1");
    cyc(2'd0, 1'b1, KA, 32'h0, 32'h0, 1'b1, KA, 2'd0);
    chk(rsp_elide == 1'b0, "R10 pre-update value at 1", rsp_elide, 0);
    look(KA, 1'b1, "R10 update applied to 2");
    upd(KA, 2'd1); upd(KA, 2'd1);
    // R10: update wins over a colliding allocation
    cyc(2'd0, 1'b1, KC, 32'h0, 32'h0, 1'b1, KA, 2'd0);
    chk(rsp_elide == 1'b1, "R10 colliding miss answers elide", rsp_elide, 1);
    look(KA, 1'b0, "R10 resident entry kept and updated");

    // R11: allocation evicts an older tag
    look(KC, 1'b1, "R11 new tag allocates");
    upd(KC, 2'd1);
    look(KC, 1'b0, "R11 new entry trained");
    look(KA, 1'b1, "R11 old tag evicted");
    upd(KA, 2'd1);
    look(KA, 1'b0, "R6 fresh counter starts weakly elide");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule